// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank SDRAM on every rising clock edge and turns them into a named command. The pins it reads are chip select, row strobe, column strobe, write enable, the clock enable, the two bank-select bits and the 13 address bits. Alongside the decoded command it keeps a table that records, for each bank, whether the bank is idle or open and which row an activate latched into it. It raises a flag when a command is not allowed in the present bank state, and such a command leaves the table untouched. The block is meant to sit beside a controller or a memory model as a protocol monitor. It checks no timing parameters and moves no data.

The block keeps a small burst counter so that it knows when a read or write burst is in flight. The burst length comes from the low address bits of the last legal mode-register command. The counter serves two purposes. It closes the bank at the end of an auto-precharge burst. It also decides what a falling clock enable means: with a burst in flight the device freezes into clock suspend, and with no burst in flight it enters power-down. A falling clock enable together with the refresh pin pattern starts self refresh instead.

A four-state power machine, built on an enumerated state, holds the operating mode. The states are RUN, SUSPEND, PDOWN and SELFREF. RUN goes to SELFREF on a self-refresh entry that is legal. Otherwise a falling clock enable takes RUN to SUSPEND when a burst is busy, and to PDOWN when none is. From SUSPEND, PDOWN or SELFREF, a high clock enable returns the machine to RUN. The pins are ignored in the exit cycle, and normal decoding starts again in the cycle after it.

Top module: `sdram_cmd_tracker`

All outputs are registered. They show the result of a pin sample one clock after the edge that took the sample.

## Requirements
- R1: When chip select is sampled high, the command output is 0 (deselect), whatever the other pins carry. The bank table, the open rows and the burst state stay as they were.
- R2: With select and row strobe low and with column strobe and write enable high, the command output is 2 (activate). If the chosen bank is idle, it becomes open and its row field takes the 13 address bits. Bank b's row occupies bits b*13 to b*13+12 of `open_rows`.
- R3: The precharge pattern (select, row strobe and write enable low, column strobe high) gives command 3 with address bit 10 low, which closes the chosen bank. With address bit 10 high it gives command 4, which closes all banks. A precharge that closes the bank of a running burst ends that burst.
- R4: The column pattern (select and column strobe low, row strobe high) gives a read when write enable is high and a write when it is low. The codes are 5 for a read, 6 for a read with auto-precharge (address bit 10 high), 7 for a write and 8 for a write with auto-precharge. A legal read or write holds `burst_busy` high for as many cycles as the burst length. The burst-length code in address bits 2..0 gives 1, 2, 4 or 8 for codes 0 to 3 and a full page for code 7, which runs until it is stopped. Reserved codes 4 to 6 count as a length of 1. The length after reset is 1.
- R5: For an auto-precharge burst, the bank closes at the same edge where `burst_busy` falls. That happens at the burst's natural end, or at a burst stop.
- R6: When all four pins are low, the command output is 9 (mode register set), and the command loads the burst-length code. It is legal only when every bank is idle.
- R7: A burst stop (select and write enable low, row and column strobes high) gives code 10 and ends a running burst at once. A no-operation (select low, the three strobes high) gives code 1.
- R8: The illegal flag rises, and neither the bank table nor the burst changes, in these cases: a read or write to an idle bank; a read or write while an auto-precharge burst is still running; an activate to an open bank; a refresh, a mode-register set or a self-refresh entry while any bank is open.
- R9: The refresh pattern (select and both strobes low, write enable high) gives code 11 while clock enable stays high. It gives code 12 when clock enable falls at that edge, and with all banks idle this enters self refresh, shown on `self_refresh`.
- R10: A falling clock enable with any other pattern, or with a refused self-refresh entry, enters clock suspend if a burst is busy and power-down if not. These show on `clock_suspend` and `power_down`. The burst count does not advance while the clock is suspended.
- R11: In suspend, power-down or self refresh, every pin pattern is ignored and the command output is 13 (hold). A high clock enable leaves the mode at that edge, the exit cycle also shows 13, and decoding resumes at the next edge.
- R12: After reset, the command output is 0, all banks are idle with rows of 0, no burst is running, the illegal flag is low and the mode is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| bank_sel | input | 2 | Bank select |
| addr | input | 13 | Address: row, bit 10 option, mode code in bits 2..0 |
| cmd_code | output | 4 | Decoded command code (see requirements) |
| illegal_cmd | output | 1 | Last command was not legal in the bank state |
| bank_open | output | 4 | One bit per bank, high when open |
| open_rows | output | 52 | Latched row per bank, 13 bits each |
| burst_busy | output | 1 | A read or write burst is in flight |
| power_down | output | 1 | Power-down mode |
| self_refresh | output | 1 | Self-refresh mode |
| clock_suspend | output | 1 | Clock-suspend mode |

## Verification
The bench aims at the edges of the burst counter. It checks that an auto-precharge burst closes its bank on exactly the fourth edge and not on the third. An off-by-one counter would close the bank a cycle early or leave it open a cycle too long. The bench also stops an auto-precharge write with a burst stop, and a design that dropped the pending precharge would leave the bank open. The clock-enable paths are driven both with and without a burst in flight, and with banks open and with banks idle. A design that used open banks rather than a running burst to pick between suspend and power-down would report the wrong mode. So would one that let the counter run on while suspended, or that decoded pins during power-down or in the exit cycle. The remaining cases cover refused commands (a second activate, a read to an idle bank, a refresh with a bank open, a self-refresh entry with a bank open). For each, the bench checks that the flag rises and that rows and open bits stay unchanged.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL  = 4'd0,
        CMD_NOP    = 4'd1,
        CMD_ACT    = 4'd2,
        CMD_PRE    = 4'd3,
        CMD_PREALL = 4'd4,
        CMD_RD     = 4'd5,
        CMD_RDA    = 4'd6,
        CMD_WR     = 4'd7,
        CMD_WRA    = 4'd8,
        CMD_MRS    = 4'd9,
        CMD_BST    = 4'd10,
        CMD_AREF   = 4'd11,
        CMD_SREF   = 4'd12,
        CMD_HOLD   = 4'd13
    } cmd_e;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_SUSPEND = 2'd1,
        PM_PDOWN   = 2'd2,
        PM_SELFREF = 2'd3
    } pmode_e;

endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic opt_bit,
    input  logic cke_prev,
    input  logic cke,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b110:  cmd = CMD_BST;
                3'b101:  cmd = opt_bit ? CMD_RDA : CMD_RD;
                3'b100:  cmd = opt_bit ? CMD_WRA : CMD_WR;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = opt_bit ? CMD_PREALL : CMD_PRE;
                3'b001:  cmd = (cke_prev && !cke) ? CMD_SREF : CMD_AREF;
                default: cmd = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
    import sdram_trk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cke,
    input  logic   sref_req,
    input  logic   sref_ok,
    input  logic   burst_busy,
    output pmode_e mode,
    output logic   power_down,
    output logic   self_refresh,
    output logic   clock_suspend
);

    pmode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (!cke) begin
                    if (sref_req && sref_ok) state_d = PM_SELFREF;
                    else if (burst_busy)     state_d = PM_SUSPEND;
                    else                     state_d = PM_PDOWN;
                end
            end
            PM_SUSPEND, PM_PDOWN, PM_SELFREF: begin
                if (cke) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        mode          = state_q;
        power_down    = (state_q == PM_PDOWN);
        self_refresh  = (state_q == PM_SELFREF);
        clock_suspend = (state_q == PM_SUSPEND);
    end

    // R9
    sref_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && !cke && sref_req && sref_ok) |=> (state_q == PM_SELFREF));

    // R11
    lowpwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PM_RUN && !cke) |=> $stable(state_q));

endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
    parameter int BANK_W       = 2,
    parameter int MODE_W       = 3,
    parameter int MAX_FIXED_BL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              start_ap,
    input  logic [BANK_W-1:0] start_bank,
    input  logic              stop,
    input  logic              pre_hit,
    input  logic              mrs_load,
    input  logic [MODE_W-1:0] mrs_code,
    output logic              busy,
    output logic              ap_pending,
    output logic              ap_close,
    output logic [BANK_W-1:0] burst_bank
);

    localparam int CNT_W = $clog2(MAX_FIXED_BL + 1);
    localparam logic [MODE_W-1:0] FULL_CODE = '1;

    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    logic              ap_q;
    logic [BANK_W-1:0] bank_q;
    logic [MODE_W-1:0] code_q;
    logic [CNT_W-1:0]  load_len;

    always_comb begin
        unique case (code_q)
            MODE_W'(0): load_len = CNT_W'(1);
            MODE_W'(1): load_len = CNT_W'(2);
            MODE_W'(2): load_len = CNT_W'(4);
            MODE_W'(3): load_len = CNT_W'(MAX_FIXED_BL);
            default:    load_len = CNT_W'(1);
        endcase
    end

    assign busy       = full_q || (cnt_q != '0);
    assign ap_pending = ap_q;
    assign burst_bank = bank_q;
    assign ap_close   = ap_q && ((run && !full_q && cnt_q == CNT_W'(1)) || stop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (mrs_load) begin
            code_q <= mrs_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
            ap_q   <= 1'b0;
            bank_q <= '0;
        end else if (start) begin
            full_q <= (code_q == FULL_CODE);
            cnt_q  <= (code_q == FULL_CODE) ? '0 : load_len;
            ap_q   <= start_ap;
            bank_q <= start_bank;
        end else if (stop || pre_hit) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            ap_q   <= 1'b0;
        end else if (run && !full_q && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) ap_q <= 1'b0;
        end
    end

    // R8
    start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !ap_q);

    // R5
    ap_close_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_close |=> !ap_pending);

    // R10
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start && !stop && !pre_hit) |=> ($stable(cnt_q) && $stable(full_q)));

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       act_en,
    input  logic                       pre_en,
    input  logic                       preall_en,
    input  logic                       ap_close,
    input  logic [BANK_W-1:0]          ap_bank,
    input  logic [BANK_W-1:0]          sel_bank,
    input  logic [ROW_W-1:0]           row_in,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] rows_flat
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic             hit_sel;
        logic             hit_ap;

        assign hit_sel = (sel_bank == BANK_W'(b));
        assign hit_ap  = ap_close && (ap_bank == BANK_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q <= 1'b0;
            end else if (preall_en || (pre_en && hit_sel) || hit_ap) begin
                open_q <= 1'b0;
            end else if (act_en && hit_sel) begin
                open_q <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                row_q <= '0;
            else if (act_en && hit_sel) row_q <= row_in;
        end

        assign bank_open[b]              = open_q;
        assign rows_flat[b*ROW_W +: ROW_W] = row_q;
    end

    // R2
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> bank_open[$past(sel_bank)]);

    // R3
    preall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preall_en |=> (bank_open == '0));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int ROW_W        = 13,
    parameter int MAX_FIXED_BL = 8,
    parameter int MODE_W       = 3,
    parameter int OPT_BIT      = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [1:0]                 bank_sel,
    input  logic [ROW_W-1:0]           addr,
    output logic [3:0]                 cmd_code,
    output logic                       illegal_cmd,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic                       burst_busy,
    output logic                       power_down,
    output logic                       self_refresh,
    output logic                       clock_suspend
);

    localparam int BANK_W = $clog2(NUM_BANKS);

    cmd_e              raw_cmd;
    cmd_e              cmd_q;
    cmd_e              cmd_d;
    pmode_e            mode;
    logic              cke_prev_q;
    logic              live, entry, any_open, sel_open, is_rw;
    logic              bad, sref_bad, ok;
    logic              ap_pending, ap_close;
    logic [BANK_W-1:0] burst_bank;
    logic              illegal_q;

    sdram_pin_decode i_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .opt_bit  (addr[OPT_BIT]),
        .cke_prev (cke_prev_q),
        .cke      (cke),
        .cmd      (raw_cmd)
    );

    always_comb begin
        live     = (mode == PM_RUN) && cke;
        entry    = (mode == PM_RUN) && !cke;
        any_open = |bank_open;
        sel_open = bank_open[bank_sel];
        is_rw    = (raw_cmd == CMD_RD) || (raw_cmd == CMD_RDA) ||
                   (raw_cmd == CMD_WR) || (raw_cmd == CMD_WRA);
        bad      = live && ((is_rw && (!sel_open || ap_pending)) ||
                            (raw_cmd == CMD_ACT && sel_open) ||
                            ((raw_cmd == CMD_AREF || raw_cmd == CMD_MRS) && any_open));
        sref_bad = entry && (raw_cmd == CMD_SREF) && any_open;
        ok       = live && !bad;
        if (live)                               cmd_d = raw_cmd;
        else if (entry && raw_cmd == CMD_SREF)  cmd_d = CMD_SREF;
        else                                    cmd_d = CMD_HOLD;
    end

    sdram_pwr_fsm i_pwr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cke           (cke),
        .sref_req      (raw_cmd == CMD_SREF),
        .sref_ok       (!any_open),
        .burst_busy    (burst_busy),
        .mode          (mode),
        .power_down    (power_down),
        .self_refresh  (self_refresh),
        .clock_suspend (clock_suspend)
    );

    sdram_burst_ctr #(
        .BANK_W       (BANK_W),
        .MODE_W       (MODE_W),
        .MAX_FIXED_BL (MAX_FIXED_BL)
    ) i_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (mode == PM_RUN),
        .start      (ok && is_rw),
        .start_ap   (raw_cmd == CMD_RDA || raw_cmd == CMD_WRA),
        .start_bank (bank_sel),
        .stop       (ok && raw_cmd == CMD_BST),
        .pre_hit    (ok && (raw_cmd == CMD_PREALL ||
                            (raw_cmd == CMD_PRE && bank_sel == burst_bank))),
        .mrs_load   (ok && raw_cmd == CMD_MRS),
        .mrs_code   (addr[MODE_W-1:0]),
        .busy       (burst_busy),
        .ap_pending (ap_pending),
        .ap_close   (ap_close),
        .burst_bank (burst_bank)
    );

    sdram_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) i_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (ok && raw_cmd == CMD_ACT),
        .pre_en    (ok && raw_cmd == CMD_PRE),
        .preall_en (ok && raw_cmd == CMD_PREALL),
        .ap_close  (ap_close),
        .ap_bank   (burst_bank),
        .sel_bank  (bank_sel),
        .row_in    (addr),
        .bank_open (bank_open),
        .rows_flat (open_rows)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_prev_q <= 1'b1;
            cmd_q      <= CMD_DESEL;
            illegal_q  <= 1'b0;
        end else begin
            cke_prev_q <= cke;
            cmd_q      <= cmd_d;
            illegal_q  <= bad || sref_bad;
        end
    end

    assign cmd_code    = cmd_q;
    assign illegal_cmd = illegal_q;

    // R1
    desel_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cs_n && !ap_close) |=> ($stable(bank_open) && $stable(open_rows)));

    // R8
    illegal_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> $stable(open_rows));

    // R6
    mrs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && raw_cmd == CMD_MRS && any_open) |=> illegal_cmd);

    // R11
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_RUN) |=> (cmd_code == CMD_HOLD));

endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  bank_sel = '0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd_code;
    logic        illegal_cmd;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;
    logic        burst_busy, power_down, self_refresh, clock_suspend;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_tracker i_sdram_cmd_tracker (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .cke (cke), .bank_sel (bank_sel), .addr (addr),
        .cmd_code (cmd_code), .illegal_cmd (illegal_cmd), .bank_open (bank_open),
        .open_rows (open_rows), .burst_busy (burst_busy), .power_down (power_down),
        .self_refresh (self_refresh), .clock_suspend (clock_suspend)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic cs, input logic ras, input logic cas, input logic we,
                         input logic [1:0] b, input logic [12:0] a, input logic k);
        @(negedge clk);
        cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; bank_sel = b; addr = a; cke = k;
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input logic k = 1'b1);        drive(0,1,1,1,2'd0,13'd0,k); endtask
    task automatic act(input logic [1:0] b, input logic [12:0] r); drive(0,0,1,1,b,r,1'b1); endtask
    task automatic rd(input logic [1:0] b, input logic ap);  drive(0,1,0,1,b,{2'b0,ap,10'b0},1'b1); endtask
    task automatic wr(input logic [1:0] b, input logic ap);  drive(0,1,0,0,b,{2'b0,ap,10'b0},1'b1); endtask
    task automatic pre(input logic [1:0] b);         drive(0,0,1,0,b,13'h0000,1'b1); endtask
    task automatic preall();                         drive(0,0,1,0,2'd0,13'h0400,1'b1); endtask
    task automatic mrs(input logic [2:0] c);         drive(0,0,0,0,2'd0,{10'b0,c},1'b1); endtask
    task automatic bst();                            drive(0,1,1,0,2'd0,13'd0,1'b1); endtask
    task automatic aref(input logic k);              drive(0,0,0,1,2'd0,13'd0,k); endtask

    task automatic t_reset();
        chk("R12 cmd", cmd_code, 0);
        chk("R12 banks", bank_open, 0);
        chk("R12 rows", open_rows, 0);
        chk("R12 illegal", illegal_cmd, 0);
        chk("R12 busy", burst_busy, 0);
        chk("R12 modes", {power_down, self_refresh, clock_suspend}, 0);
    endtask

    task automatic t_activate();
        act(2'd2, 13'h1ABC);
        chk("R2 act code", cmd_code, 2);
        chk("R2 open", bank_open, 4'b0100);
        chk("R2 row", open_rows[26 +: 13], 13'h1ABC);
        act(2'd0, 13'h0005);
        chk("R2 open b0", bank_open, 4'b0101);
        act(2'd2, 13'h0123);
        chk("R8 double act flag", illegal_cmd, 1);
        chk("R8 row kept", open_rows[26 +: 13], 13'h1ABC);
        chk("R8 open kept", bank_open, 4'b0101);
    endtask

    task automatic t_deselect();
        drive(1,0,1,1,2'd1,13'h0777,1'b1);
        chk("R1 desel code", cmd_code, 0);
        chk("R1 open kept", bank_open, 4'b0101);
        chk("R1 row1 kept", open_rows[13 +: 13], 0);
        chk("R1 no flag", illegal_cmd, 0);
    endtask

    task automatic t_read_basic();
        rd(2'd2, 1'b0);
        chk("R4 read code", cmd_code, 5);
        chk("R4 busy", burst_busy, 1);
        nop();
        chk("R7 nop code", cmd_code, 1);
        chk("R4 bl1 end", burst_busy, 0);
        rd(2'd3, 1'b0);
        chk("R8 read idle flag", illegal_cmd, 1);
        chk("R8 read idle no burst", burst_busy, 0);
        wr(2'd0, 1'b0);
        chk("R4 write code", cmd_code, 7);
        nop();
    endtask

    task automatic t_precharge();
        mrs(3'd2);
        chk("R6 mrs open flag", illegal_cmd, 1);
        pre(2'd0);
        chk("R3 pre code", cmd_code, 3);
        chk("R3 pre one", bank_open, 4'b0100);
        preall();
        chk("R3 preall code", cmd_code, 4);
        chk("R3 preall banks", bank_open, 0);
        mrs(3'd2);
        chk("R6 mrs code", cmd_code, 9);
        chk("R6 mrs legal", illegal_cmd, 0);
    endtask

    task automatic t_autopre();
        act(2'd1, 13'h0010);
        rd(2'd1, 1'b1);
        chk("R4 rda code", cmd_code, 6);
        for (int i = 0; i < 3; i++) nop();
        chk("R5 still open edge3", bank_open, 4'b0010);
        chk("R4 busy edge3", burst_busy, 1);
        nop();
        chk("R5 closed edge4", bank_open, 0);
        chk("R4 idle edge4", burst_busy, 0);
    endtask

    task automatic t_ap_stop();
        act(2'd1, 13'h0020);
        act(2'd3, 13'h0030);
        wr(2'd1, 1'b1);
        chk("R4 wra code", cmd_code, 8);
        rd(2'd3, 1'b0);
        chk("R8 rw during ap flag", illegal_cmd, 1);
        bst();
        chk("R7 bst code", cmd_code, 10);
        chk("R7 bst ends", burst_busy, 0);
        chk("R5 stop closes", bank_open, 4'b1000);
        preall();
    endtask

    task automatic t_fullpage();
        mrs(3'd7);
        act(2'd0, 13'h0040);
        rd(2'd0, 1'b0);
        for (int i = 0; i < 10; i++) nop();
        chk("R4 full page busy", burst_busy, 1);
        bst();
        chk("R7 full page stop", burst_busy, 0);
        chk("R7 bank stays", bank_open, 4'b0001);
    endtask

    task automatic t_suspend();
        rd(2'd0, 1'b0);
        nop(1'b0);
        chk("R10 suspend", {power_down, clock_suspend}, 2'b01);
        chk("R11 hold code", cmd_code, 13);
        drive(0,0,1,1,2'd2,13'h0999,1'b0);
        chk("R11 act ignored", bank_open, 4'b0001);
        chk("R11 hold code 2", cmd_code, 13);
        nop(1'b0);
        nop(1'b1);
        chk("R11 exit suspend", clock_suspend, 0);
        chk("R11 exit code", cmd_code, 13);
        nop(1'b1);
        chk("R11 decode resumes", cmd_code, 1);
        chk("R10 burst kept", burst_busy, 1);
        bst();
        preall();
    endtask

    task automatic t_powerdown();
        nop(1'b0);
        chk("R10 power down", {power_down, clock_suspend}, 2'b10);
        drive(0,0,1,1,2'd1,13'h0abc,1'b0);
        chk("R11 pd act ignored", bank_open, 0);
        nop(1'b1);
        chk("R11 pd exit", power_down, 0);
        chk("R11 pd exit code", cmd_code, 13);
        act(2'd3, 13'h0055);
        chk("R11 act after exit", bank_open, 4'b1000);
        nop(1'b0);
        chk("R10 active pd", {power_down, clock_suspend}, 2'b10);
        nop(1'b1);
        preall();
    endtask

    task automatic t_selfref();
        aref(1'b0);
        chk("R9 sref code", cmd_code, 12);
        chk("R9 sref mode", self_refresh, 1);
        chk("R9 sref legal", illegal_cmd, 0);
        nop(1'b0);
        chk("R9 sref held", self_refresh, 1);
        nop(1'b1);
        chk("R11 sref exit", self_refresh, 0);
        aref(1'b1);
        chk("R9 aref code", cmd_code, 11);
        chk("R9 aref legal", illegal_cmd, 0);
        act(2'd2, 13'h0001);
        aref(1'b1);
        chk("R8 aref open flag", illegal_cmd, 1);
        aref(1'b0);
        chk("R8 sref open flag", illegal_cmd, 1);
        chk("R10 refused sref pd", {power_down, self_refresh}, 2'b10);
        nop(1'b1);
        preall();
    endtask

    task automatic t_reserved();
        mrs(3'd5);
        act(2'd0, 13'h0001);
        rd(2'd0, 1'b0);
        chk("R4 reserved busy", burst_busy, 1);
        nop();
        chk("R4 reserved len1", burst_busy, 0);
        preall();
    endtask

    task automatic t_pre_ends();
        mrs(3'd7);
        act(2'd3, 13'h0002);
        rd(2'd3, 1'b0);
        nop();
        pre(2'd2);
        chk("R3 other pre keeps burst", burst_busy, 1);
        pre(2'd3);
        chk("R3 pre ends burst", burst_busy, 0);
        chk("R3 pre closes", bank_open, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_activate();
        t_deselect();
        t_read_basic();
        t_precharge();
        t_autopre();
        t_ap_stop();
        t_fullpage();
        t_suspend();
        t_powerdown();
        t_selfref();
        t_reserved();
        t_pre_ends();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule